// File: doc/BRIEF.md
# Half-Flash Converter Conversion Sequencer

This block is the digital timing and control core of a parallel-output 8-bit converter that resolves its result in two half-width passes. A coarse pass reads a 15-line thermometer code and yields the upper nibble. A fine pass reads a second 15-line thermometer code, taken from the residue, and yields the lower nibble. The analog comparators are replaced by the two thermometer inputs, so every step can be checked on a clock edge.

A host talks to it over a plain strobe bus. The bus has an active-low select, an active-low read strobe, an active-low write strobe and a mode pin. With the mode pin low, a read strobe alone starts a conversion, and a ready line is pulled while the host waits. With the mode pin high, a write strobe starts the conversion and a later read fetches the result. A read during the fine pass ends that pass at once. Tying select and read low gives a free-running write-only use. An active-low sleep input aborts work and closes a wake window. A second window, the acquisition time after each result, also rejects starts. Every rejected start is reported with a one-cycle flag. All delays are parameters counted in clock cycles. There is no data stream here, so every pin is a plain level.

Top module: `hf_conv_ctrl`

## Requirements
- R1: After reset, q is 0, done_n is 1, busy_pull is 0 and start_drop is 0.
- R2: The result q holds the number of ones in cmp_coarse in bits 7:4 and the number of ones in cmp_fine in bits 3:0.
- R3: With wr_mode at 0 and sel_n low, a falling rdreq_n seen at clock edge E makes done_n fall at edge E+2·PHASE_CYC, with the full result on q. done_n is still high one edge earlier.
- R4: With wr_mode at 1 and sel_n low, a falling wrreq_n starts a conversion and drives done_n high. The rising wrreq_n seen at edge E puts the coarse nibble on q[7:4] at E. The lower nibble is written and done_n falls at edge E+PHASE_CYC.
- R5: In write-read mode, a falling rdreq_n with sel_n low during the fine pass writes the lower nibble and drops done_n at that same edge.
- R6: q_oe is 1 exactly while sel_n and rdreq_n are both low.
- R7: done_n returns to 1 at the edge that sees a rising sel_n or a rising rdreq_n.
- R8: In read mode, busy_pull goes to 1 at the edge that sees sel_n fall. It returns to 0 when done_n falls or sel_n rises. It stays 0 while wr_mode is 1.
- R9: With sel_n and rdreq_n held low in write-read mode, each falling wrreq_n starts a conversion. The previous result is still on q after that falling edge.
- R10: While sleep_n is low, any conversion is abandoned and q does not change. A start seen within WAKE_CYC edges after sleep_n goes high, or after reset, is dropped.
- R11: A start seen within ACQ_CYC edges after done_n falls is dropped.
- R12: A dropped start pulses start_drop for one cycle and leaves q and done_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low chip select |
| rdreq_n | input | 1 | Active-low read strobe |
| wrreq_n | input | 1 | Active-low write strobe |
| sleep_n | input | 1 | Active-low shutdown |
| wr_mode | input | 1 | 0: read-started mode, 1: write-read mode |
| cmp_coarse | input | 15 | Coarse-pass thermometer code |
| cmp_fine | input | 15 | Fine-pass thermometer code |
| q | output | 8 | Result register |
| q_oe | output | 1 | Data bus drive enable |
| done_n | output | 1 | Active-low end-of-conversion |
| busy_pull | output | 1 | Enable for pulling the ready line low |
| start_drop | output | 1 | One-cycle pulse for a rejected start |

## Verification
The bench builds the block with PHASE_CYC=3, WAKE_CYC=10 and ACQ_CYC=5. A three-cycle pass leaves a one-cycle gap between the early read and normal completion in write-read mode, so the early-completion case shows up as an earlier edge. The short wake and acquisition windows let the bench fire a start inside each window and again after it, within a few dozen cycles.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMP,
    ST_HI,
    ST_LO
  } hf_st_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
  parameter int W = 4
) (
  input  logic [(1<<W)-2:0] therm,
  output logic [W-1:0]      code
);
  localparam int N = (1 << W) - 1;
  logic [W:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + {{W{1'b0}}, therm[i]};
    end
  end
  assign code = acc[W-1:0];
endmodule

// File: rtl/hf_edges.sv
module hf_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end
  for (genvar g = 0; g < N; g++) begin : g_edge
    assign fall[g] = prev[g] & ~lvl[g];
    assign rise[g] = ~prev[g] & lvl[g];
  end
endmodule

// File: rtl/hf_gate.sv
module hf_gate #(
  parameter int WAKE_CYC = 24,
  parameter int ACQ_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic acq_load,
  output logic open_q
);
  localparam int WW = $clog2(WAKE_CYC + 1) < 1 ? 1 : $clog2(WAKE_CYC + 1);
  localparam int AW = $clog2(ACQ_CYC + 1) < 1 ? 1 : $clog2(ACQ_CYC + 1);
  localparam logic [WW-1:0] WAKE_INIT = WW'(WAKE_CYC);
  localparam logic [AW-1:0] ACQ_INIT  = AW'(ACQ_CYC);

  logic [WW-1:0] wake_cnt;
  logic [AW-1:0] acq_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                wake_cnt <= WAKE_INIT;
    else if (!sleep_n)         wake_cnt <= WAKE_INIT;
    else if (wake_cnt != '0)   wake_cnt <= wake_cnt - WW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                acq_cnt <= '0;
    else if (acq_load)         acq_cnt <= ACQ_INIT;
    else if (acq_cnt != '0)    acq_cnt <= acq_cnt - AW'(1);
  end

  assign open_q = sleep_n && (wake_cnt == '0) && (acq_cnt == '0);
endmodule

// File: rtl/hf_conv_ctrl.sv
module hf_conv_ctrl #(
  parameter int HALF_W    = 4,
  parameter int PHASE_CYC = 4,
  parameter int WAKE_CYC  = 24,
  parameter int ACQ_CYC   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_n,
  input  logic                     rdreq_n,
  input  logic                     wrreq_n,
  input  logic                     sleep_n,
  input  logic                     wr_mode,
  input  logic [(1<<HALF_W)-2:0]   cmp_coarse,
  input  logic [(1<<HALF_W)-2:0]   cmp_fine,
  output logic [2*HALF_W-1:0]      q,
  output logic                     q_oe,
  output logic                     done_n,
  output logic                     busy_pull,
  output logic                     start_drop
);
  import hf_pkg::*;

  localparam int CMP_N = (1 << HALF_W) - 1;
  localparam int OUT_W = 2 * HALF_W;
  localparam int CW    = $clog2(PHASE_CYC + 1);
  localparam logic [CW-1:0] PH_LAST = CW'(PHASE_CYC - 1);

  // bus strobe edges: bit 0 select, bit 1 read, bit 2 write
  logic [2:0] fall, rise;
  hf_edges #(.N(3)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({wrreq_n, rdreq_n, sel_n}),
    .fall (fall),
    .rise (rise)
  );
  logic sel_fall, sel_rise, rd_fall, rd_rise, wr_fall, wr_rise;
  assign sel_fall = fall[0];
  assign sel_rise = rise[0];
  assign rd_fall  = fall[1];
  assign rd_rise  = rise[1];
  assign wr_fall  = fall[2];
  assign wr_rise  = rise[2];

  // one encoder per pass
  logic [CMP_N-1:0]  therm_arr [2];
  logic [HALF_W-1:0] code_arr  [2];
  assign therm_arr[0] = cmp_coarse;
  assign therm_arr[1] = cmp_fine;
  for (genvar g = 0; g < 2; g++) begin : g_enc
    hf_therm_enc #(.W(HALF_W)) u_enc (
      .therm(therm_arr[g]),
      .code (code_arr[g])
    );
  end

  hf_st_e       st;
  logic [CW-1:0] cnt;
  logic gate_open, start_req, accept, drop, early, lo_done;

  assign start_req = (st == ST_IDLE) && !sel_n &&
                     ((!wr_mode && rd_fall) || (wr_mode && wr_fall));
  assign accept    = start_req && gate_open;
  assign drop      = start_req && !gate_open;
  assign early     = wr_mode && (st == ST_LO) && rd_fall && !sel_n;
  assign lo_done   = sleep_n && (st == ST_LO) && ((cnt == '0) || early);

  hf_gate #(.WAKE_CYC(WAKE_CYC), .ACQ_CYC(ACQ_CYC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .acq_load(lo_done),
    .open_q  (gate_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      q          <= '0;
      done_n     <= 1'b1;
      start_drop <= 1'b0;
    end else begin
      start_drop <= drop;
      if (sel_rise || rd_rise) done_n <= 1'b1;
      if (!sleep_n) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (accept) begin
            done_n <= 1'b1;
            if (wr_mode) begin
              st <= ST_SAMP;
            end else begin
              st  <= ST_HI;
              cnt <= PH_LAST;
            end
          end
          ST_SAMP: if (wr_rise) begin
            q[OUT_W-1:HALF_W] <= code_arr[0];
            st  <= ST_LO;
            cnt <= PH_LAST;
          end
          ST_HI: if (cnt == '0) begin
            q[OUT_W-1:HALF_W] <= code_arr[0];
            st  <= ST_LO;
            cnt <= PH_LAST;
          end else begin
            cnt <= cnt - CW'(1);
          end
          ST_LO: if (lo_done) begin
            q[HALF_W-1:0] <= code_arr[1];
            done_n <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   busy_pull <= 1'b0;
    else if (wr_mode)             busy_pull <= 1'b0;
    else if (sel_rise || lo_done) busy_pull <= 1'b0;
    else if (sel_fall)            busy_pull <= 1'b1;
  end

  assign q_oe = !sel_n && !rdreq_n;
endmodule

// File: rtl/hf_conv_chk.sv
module hf_conv_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             rdreq_n,
  input logic             wrreq_n,
  input logic             sleep_n,
  input logic             wr_mode,
  input logic [OUT_W-1:0] q,
  input logic             done_n,
  input logic             busy_pull,
  input logic             start_drop
);
  AST_DONE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_n) |-> (($past(sel_n) && !$past(sel_n, 2)) ||
                       ($past(rdreq_n) && !$past(rdreq_n, 2)) ||
                       (!$past(rdreq_n) && $past(rdreq_n, 2)) ||
                       (!$past(wrreq_n) && $past(wrreq_n, 2)))); // R7

  AST_NO_READY_WR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> !busy_pull); // R8

  AST_READY_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> !busy_pull); // R8

  AST_SLEEP_HOLDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> $stable(q)); // R10

  AST_DROP_HOLDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |-> $stable(q)); // R12
endmodule

bind hf_conv_ctrl hf_conv_chk #(.OUT_W(2*HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .rdreq_n   (rdreq_n),
  .wrreq_n   (wrreq_n),
  .sleep_n   (sleep_n),
  .wr_mode   (wr_mode),
  .q         (q),
  .done_n    (done_n),
  .busy_pull (busy_pull),
  .start_drop(start_drop)
);

// File: tb/hf_conv_ctrl_bench.sv
module hf_conv_ctrl_bench;
  localparam int PH = 3;
  localparam int WK = 10;
  localparam int AQ = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, rdreq_n = 1'b1, wrreq_n = 1'b1, sleep_n = 1'b1, wr_mode = 1'b0;
  logic [14:0] cmp_coarse = '0, cmp_fine = '0;
  logic [7:0] q;
  logic q_oe, done_n, busy_pull, start_drop;

  always #5 clk = ~clk;

  hf_conv_ctrl #(.HALF_W(4), .PHASE_CYC(PH), .WAKE_CYC(WK), .ACQ_CYC(AQ)) u_hf_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rdreq_n(rdreq_n), .wrreq_n(wrreq_n),
    .sleep_n(sleep_n), .wr_mode(wr_mode), .cmp_coarse(cmp_coarse), .cmp_fine(cmp_fine),
    .q(q), .q_oe(q_oe), .done_n(done_n), .busy_pull(busy_pull), .start_drop(start_drop)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver helper: set thermometer counts and queue the expected result
  task automatic load(input int hi, input int lo, input bit push);
    cmp_coarse = 15'((32'd1 << hi) - 1);
    cmp_fine   = 15'((32'd1 << lo) - 1);
    if (push) exp_q.push_back(8'((hi << 4) | lo));
  endtask

  // monitor: every falling done_n must deliver the next queued result
  logic prev_done = 1'b1;
  always @(negedge clk) begin
    if (rst_n && prev_done && !done_n) begin
      if (exp_q.size() == 0) chk("R2", "unexpected result", int'(q), -1);
      else chk("R2", "result", int'(q), int'(exp_q.pop_front()));
    end
    prev_done = done_n;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    chk("R1", "q", int'(q), 0);
    chk("R1", "done_n", int'(done_n), 1);
    chk("R1", "busy_pull", int'(busy_pull), 0);
    chk("R1", "start_drop", int'(start_drop), 0);
    // start right after reset falls inside wake window
    step(1); sel_n = 1'b0;
    step(1); rdreq_n = 1'b0;
    step(1); chk("R10", "drop after reset", int'(start_drop), 1);
    step(1); chk("R12", "drop one cycle", int'(start_drop), 0);
    chk("R12", "done_n held", int'(done_n), 1);
    rdreq_n = 1'b1;
    step(12);

    // read mode conversion
    load(9, 5, 1);
    chk("R8", "busy after select", int'(busy_pull), 1);
    rdreq_n = 1'b0;
    step(2*PH);
    chk("R3", "done_n one edge early", int'(done_n), 1);
    chk("R8", "busy during conversion", int'(busy_pull), 1);
    step(1);
    chk("R3", "done_n at end", int'(done_n), 0);
    chk("R2", "q value", int'(q), 8'h95);
    chk("R8", "busy released", int'(busy_pull), 0);
    chk("R6", "q_oe on", int'(q_oe), 1);
    rdreq_n = 1'b1;
    #1 chk("R6", "q_oe off", int'(q_oe), 0);
    step(1);
    chk("R7", "done release on read rise", int'(done_n), 1);
    rdreq_n = 1'b0;
    step(1);
    chk("R11", "drop in acquisition", int'(start_drop), 1);
    chk("R12", "q held on drop", int'(q), 8'h95);
    rdreq_n = 1'b1;
    step(8);

    // read mode, select rise releases
    load(15, 0, 1);
    rdreq_n = 1'b0;
    step(2*PH+1);
    chk("R3", "done_n full scale", int'(done_n), 0);
    sel_n = 1'b1;
    step(1);
    chk("R7", "done release on select rise", int'(done_n), 1);
    rdreq_n = 1'b1;
    step(8);
    sel_n = 1'b0;
    step(1);
    chk("R8", "busy set on select fall", int'(busy_pull), 1);

    // write-read mode
    wr_mode = 1'b1;
    step(1);
    chk("R8", "busy off in write mode", int'(busy_pull), 0);
    load(3, 12, 1);
    wrreq_n = 1'b0;
    step(2);
    wrreq_n = 1'b1;
    step(1);
    chk("R4", "upper nibble at write rise", int'(q[7:4]), 3);
    chk("R4", "done_n high", int'(done_n), 1);
    step(PH-1);
    chk("R4", "done_n one edge early", int'(done_n), 1);
    step(1);
    chk("R4", "done_n at end", int'(done_n), 0);
    rdreq_n = 1'b0;
    #1 chk("R6", "q_oe read", int'(q_oe), 1);
    step(1); rdreq_n = 1'b1;
    step(1);
    chk("R7", "release after read", int'(done_n), 1);
    step(8);

    // early completion
    load(7, 1, 1);
    wrreq_n = 1'b0;
    step(2);
    wrreq_n = 1'b1;
    step(1);
    rdreq_n = 1'b0;
    step(1);
    chk("R5", "done_n early", int'(done_n), 0);
    chk("R5", "q early", int'(q), 8'h71);
    rdreq_n = 1'b1;
    step(9);

    // stand-alone: select and read held low
    rdreq_n = 1'b0;
    load(10, 6, 1);
    wrreq_n = 1'b0;
    step(2);
    wrreq_n = 1'b1;
    step(PH+1);
    chk("R9", "stand-alone done", int'(done_n), 0);
    step(8);
    load(2, 13, 1);
    wrreq_n = 1'b0;
    step(1);
    chk("R9", "old result at write fall", int'(q), 8'hA6);
    chk("R9", "done_n released by start", int'(done_n), 1);
    wrreq_n = 1'b1;
    step(1);
    chk("R4", "upper nibble stand-alone", int'(q), 8'h26);
    step(PH);
    rdreq_n = 1'b1;
    step(8);

    // sleep
    wr_mode = 1'b0;
    load(4, 4, 0);
    rdreq_n = 1'b0;
    step(2);
    sleep_n = 1'b0;
    step(1);
    chk("R10", "q held in sleep", int'(q), 8'h2D);
    step(2*PH+2);
    chk("R10", "no result in sleep", int'(done_n), 1);
    chk("R10", "q still held", int'(q), 8'h2D);
    rdreq_n = 1'b1;
    sleep_n = 1'b1;
    step(2);
    rdreq_n = 1'b0;
    step(1);
    chk("R10", "drop during wake", int'(start_drop), 1);
    rdreq_n = 1'b1;
    step(12);
    load(4, 4, 1);
    rdreq_n = 1'b0;
    step(2*PH+1);
    chk("R3", "done after wake", int'(done_n), 0);
    chk("R2", "q after wake", int'(q), 8'h44);
    rdreq_n = 1'b1;
    step(3);

    chk("R12", "queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule